// File: doc/BRIEF.md
# Multi-Lane Block Word-Count Allocator

This block sits in front of a code-block input stream that moves soft values (decode) or hard-bit bytes (encode) over one, two or four 128-bit lanes. At the start of each code block it is given the block length in words. After that, it receives a stream of requested word counts, one transfer per data beat. A count is either one shared 8-bit value that every active lane uses, or one 8-bit value per lane. For each beat it works out how many words each lane really carries, so that no beat holds words of two blocks.

Lanes are served in ascending order. Each lane takes the smaller of its own request and the words still left once the lower lanes have taken theirs. Each grant also comes out as a per-lane mask of valid word slots, packed from the least significant slot. A count transfer that would move no data is absorbed, and no beat is issued for it. Every issued beat carries a computed last-of-block flag. Framing is never taken from the producer. Instead, the producer's data-side TLAST and the count stream's TLAST are checked against the computed framing, and any mismatch sets a sticky error flag and raises an interrupt.

Top module: `lane_word_allocator`

## Requirements
- R1: While reset is held and right after it, grantValid, cntReady, errIrq and both errFlags bits are 0, and no block is in progress.
- R2: In a cycle with blkStart high, the block length blkLen is loaded, no grant is offered and cntReady is 0. A length of 0 leaves the block idle, with cntReady low afterwards.
- R3: laneCfg selects the active lanes: 0 gives one lane, 1 gives two, and 2 or 3 gives four. When perLaneMode is 0, cntData bits 7:0 are the request of every active lane and the other bits are ignored. When it is 1, lane n requests cntData bits 8n+7:8n. Inactive lanes are always granted 0.
- R4: A lane request above 16 is treated as 16.
- R5: Lane n is granted the minimum of its request and the words remaining in the block minus the grants of lanes below n. For example, requests 8,4,2,1 with 13 words remaining give 8,4,1,0. Grant n appears on grantWords bits 8n+7:8n.
- R6: On every accepted beat (grantValid and grantReady), the remaining count drops by the sum of the grants. grantLast is high exactly when that sum equals the words remaining. After that beat the block is idle.
- R7: While a block is in progress, a count transfer whose grants sum to 0 is accepted (cntReady high) and produces no beat (grantValid low).
- R8: When the grants sum to a nonzero value, cntReady follows grantReady. While grantReady is low, the remaining count does not change.
- R9: Bit 16n+k of grantMask is 1 exactly when k is less than the grant of lane n.
- R10: On an accepted beat, a data-side dinLast that differs from grantLast sets errFlags bit 0.
- R11: An accepted count transfer with cntLast low sets errFlags bit 1.
- R12: The errFlags bits stay set until reset. Both bits can be set in the same cycle, and errIrq is the OR of the two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blkStart | input | 1 | Start a new block and load blkLen |
| blkLen | input | 16 | Block length in words |
| perLaneMode | input | 1 | 0: one shared count, 1: one count per lane |
| laneCfg | input | 2 | Active lanes: 0 gives 1, 1 gives 2, 2 or 3 gives 4 |
| cntValid | input | 1 | Count transfer valid |
| cntReady | output | 1 | Count transfer accepted |
| cntData | input | 32 | Requested counts, 8 bits per lane |
| cntLast | input | 1 | Count stream TLAST, expected high on every transfer |
| grantValid | output | 1 | Beat grant valid |
| grantReady | input | 1 | Downstream accepts the beat |
| grantWords | output | 32 | Granted words per lane, 8 bits per lane |
| grantMask | output | 64 | Valid word slots, 16 per lane, packed from slot 0 |
| grantLast | output | 1 | Beat ends the block |
| dinLast | input | 1 | Producer's data TLAST for the current beat |
| errFlags | output | 2 | Sticky errors: bit 0 data TLAST mismatch, bit 1 count TLAST low |
| errIrq | output | 1 | Error interrupt, OR of errFlags |

## Verification
Two error sources can fire in the same cycle: the data-side TLAST check on an accepted beat, and the count-stream TLAST check on the count transfer that beat consumes. The bench drives a beat with cntLast low and dinLast set to the inverse of the computed last flag. It then expects both flag bits to set together on the next cycle and to stay set through all later traffic. A block start that arrives while a count is pending, and the stall on a zero-sum request, are also driven. The behavioural model judges every cycle, and the model's expectation for each of these cases is fixed by the requirements alone.

// File: rtl/lwa_pkg.sv
package lwa_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLen;   // capture a new block length
    logic consume;   // a beat was accepted: subtract its words
  } dp_strobe_t;

endpackage

// File: rtl/lwa_datapath.sv
module lwa_datapath
  import lwa_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int CNT_W     = 8,
  parameter int MAX_WORDS = 16,
  parameter int LEN_W     = 16,
  parameter int CFG_W     = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dp_strobe_t                 strobe,
  input  logic [LEN_W-1:0]           blkLen,
  input  logic                       perLaneMode,
  input  logic [CFG_W-1:0]           laneCfg,
  input  logic [LANES*CNT_W-1:0]     cntData,
  output logic [LEN_W-1:0]           remWords,
  output logic [LANES*CNT_W-1:0]     grantWords,
  output logic [LANES*MAX_WORDS-1:0] grantMask,
  output logic                       beatEmpty,
  output logic                       beatFinal
);

  localparam int ACT_W = $clog2(LANES + 1);
  localparam int TWO   = (LANES < 2) ? LANES : 2;
  localparam int FOUR  = (LANES < 4) ? LANES : 4;

  logic [ACT_W-1:0] activeCount;
  logic [CNT_W-1:0] laneReq  [LANES];
  logic [CNT_W-1:0] grantArr [LANES];
  logic [LEN_W-1:0] leftAfter;
  logic [LEN_W-1:0] beatSum;
  logic [LEN_W-1:0] remReg;

  always_comb begin
    case (laneCfg)
      2'd0:    activeCount = ACT_W'(1);
      2'd1:    activeCount = ACT_W'(TWO);
      default: activeCount = ACT_W'(FOUR);
    endcase
  end

  // Request selection and saturation per lane
  for (genvar n = 0; n < LANES; n++) begin : g_req
    logic [CNT_W-1:0] rawReq;
    logic             laneOn;
    assign rawReq = perLaneMode ? cntData[n*CNT_W +: CNT_W] : cntData[CNT_W-1:0];
    assign laneOn = (ACT_W'(n) < activeCount);
    assign laneReq[n] = !laneOn ? '0 :
                        (rawReq > CNT_W'(MAX_WORDS)) ? CNT_W'(MAX_WORDS) : rawReq;
  end

  // Clip in ascending lane order against the words still left
  always_comb begin
    leftAfter = remReg;
    for (int n = 0; n < LANES; n++) begin
      if (LEN_W'(laneReq[n]) < leftAfter) grantArr[n] = laneReq[n];
      else                                grantArr[n] = leftAfter[CNT_W-1:0];
      leftAfter = leftAfter - LEN_W'(grantArr[n]);
    end
  end

  assign beatSum   = remReg - leftAfter;
  assign beatEmpty = (beatSum == '0);
  assign beatFinal = (leftAfter == '0) && !beatEmpty;

  // Output packing and LSB-first slot masks
  for (genvar n = 0; n < LANES; n++) begin : g_out
    assign grantWords[n*CNT_W +: CNT_W] = grantArr[n];
    for (genvar k = 0; k < MAX_WORDS; k++) begin : g_slot
      assign grantMask[n*MAX_WORDS + k] = (CNT_W'(k) < grantArr[n]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               remReg <= '0;
    else if (strobe.loadLen) remReg <= blkLen;
    else if (strobe.consume) remReg <= remReg - beatSum;
  end

  assign remWords = remReg;

endmodule

// File: rtl/lwa_ctrl.sv
module lwa_ctrl
  import lwa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       blkStart,
  input  logic       lenNonZero,
  input  logic       cntValid,
  input  logic       cntLast,
  input  logic       grantReady,
  input  logic       dinLast,
  input  logic       beatEmpty,
  input  logic       beatFinal,
  output dp_strobe_t strobe,
  output logic       cntReady,
  output logic       grantValid,
  output logic       grantLast,
  output logic [1:0] errFlags,
  output phase_e     phase
);

  logic busy;
  logic beatTaken;
  logic cntTaken;
  logic dataLastBad;
  logic cntLastBad;

  assign busy       = (phase == PH_RUN) && !blkStart;
  assign grantValid = busy && cntValid && !beatEmpty;
  assign cntReady   = busy && (beatEmpty || grantReady);
  assign grantLast  = grantValid && beatFinal;

  assign beatTaken   = grantValid && grantReady;
  assign cntTaken    = cntValid && cntReady;
  assign dataLastBad = beatTaken && (dinLast != beatFinal);
  assign cntLastBad  = cntTaken && !cntLast;

  always_comb begin
    strobe         = '0;
    strobe.loadLen = blkStart;
    strobe.consume = beatTaken;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       phase <= PH_IDLE;
    else if (blkStart)               phase <= lenNonZero ? PH_RUN : PH_IDLE;
    else if (beatTaken && beatFinal) phase <= PH_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlags <= 2'b00;
    else begin
      if (dataLastBad) errFlags[0] <= 1'b1;
      if (cntLastBad)  errFlags[1] <= 1'b1;
    end
  end

endmodule

// File: rtl/lane_word_allocator.sv
module lane_word_allocator
  import lwa_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int CNT_W     = 8,
  parameter int MAX_WORDS = 16,
  parameter int LEN_W     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       blkStart,
  input  logic [LEN_W-1:0]           blkLen,
  input  logic                       perLaneMode,
  input  logic [1:0]                 laneCfg,
  input  logic                       cntValid,
  output logic                       cntReady,
  input  logic [LANES*CNT_W-1:0]     cntData,
  input  logic                       cntLast,
  output logic                       grantValid,
  input  logic                       grantReady,
  output logic [LANES*CNT_W-1:0]     grantWords,
  output logic [LANES*MAX_WORDS-1:0] grantMask,
  output logic                       grantLast,
  input  logic                       dinLast,
  output logic [1:0]                 errFlags,
  output logic                       errIrq
);

  dp_strobe_t       strobe;
  logic [LEN_W-1:0] remWords;
  logic             beatEmpty;
  logic             beatFinal;
  phase_e           phase;
  logic             phaseRun;

  lwa_datapath #(
    .LANES(LANES), .CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W), .CFG_W(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blkLen(blkLen),
    .perLaneMode(perLaneMode), .laneCfg(laneCfg), .cntData(cntData),
    .remWords(remWords), .grantWords(grantWords), .grantMask(grantMask),
    .beatEmpty(beatEmpty), .beatFinal(beatFinal)
  );

  lwa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .blkStart(blkStart), .lenNonZero(blkLen != '0),
    .cntValid(cntValid), .cntLast(cntLast), .grantReady(grantReady),
    .dinLast(dinLast), .beatEmpty(beatEmpty), .beatFinal(beatFinal),
    .strobe(strobe), .cntReady(cntReady), .grantValid(grantValid),
    .grantLast(grantLast), .errFlags(errFlags), .phase(phase)
  );

  assign phaseRun = (phase == PH_RUN);
  assign errIrq   = |errFlags;

endmodule

// File: rtl/lwa_checker.sv
module lwa_checker #(
  parameter int LANES     = 4,
  parameter int CNT_W     = 8,
  parameter int MAX_WORDS = 16,
  parameter int LEN_W     = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       blkStart,
  input logic [1:0]                 laneCfg,
  input logic                       cntReady,
  input logic                       grantValid,
  input logic                       grantReady,
  input logic                       grantLast,
  input logic [LANES*CNT_W-1:0]     grantWords,
  input logic [LANES*MAX_WORDS-1:0] grantMask,
  input logic [LEN_W-1:0]           remWords,
  input logic                       phaseRun,
  input logic [1:0]                 errFlags
);

  logic [LEN_W-1:0] sumGrant;
  always_comb begin
    sumGrant = '0;
    for (int n = 0; n < LANES; n++)
      sumGrant = sumGrant + LEN_W'(grantWords[n*CNT_W +: CNT_W]);
  end

  AST_START_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    blkStart |-> (!grantValid && !cntReady));                            // R2
  AST_GRANT_FITS: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (sumGrant <= remWords));                              // R5
  AST_LAST_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    grantLast |-> (sumGrant == remWords));                               // R6
  AST_LAST_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (grantLast && grantReady) |=> !phaseRun);                            // R6
  AST_PHASE_REM: assert property (@(posedge clk) disable iff (!rstN)
    phaseRun == (remWords != '0));                                       // R6
  AST_NO_EMPTY_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (sumGrant != '0));                                    // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantReady) |=> $stable(remWords));                  // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(errFlags) & ~errFlags) == 2'b00);                             // R12

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    AST_LANE_CAP: assert property (@(posedge clk) disable iff (!rstN)
      grantWords[n*CNT_W +: CNT_W] <= CNT_W'(MAX_WORDS));                // R4
    AST_MASK_PACKED: assert property (@(posedge clk) disable iff (!rstN)
      grantMask[n*MAX_WORDS +: MAX_WORDS] ==
        MAX_WORDS'((1 << grantWords[n*CNT_W +: CNT_W]) - 1));            // R9
    if (n > 0) begin : g_off
      AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rstN)
        (laneCfg == 2'd0) |-> (grantWords[n*CNT_W +: CNT_W] == '0));     // R3
    end
  end

endmodule

bind lane_word_allocator lwa_checker #(
  .LANES(LANES), .CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)
) u_lwa_checker (
  .clk(clk), .rstN(rstN), .blkStart(blkStart), .laneCfg(laneCfg),
  .cntReady(cntReady), .grantValid(grantValid), .grantReady(grantReady),
  .grantLast(grantLast), .grantWords(grantWords), .grantMask(grantMask),
  .remWords(remWords), .phaseRun(phaseRun), .errFlags(errFlags)
);

// File: tb/lane_word_allocator_bench.sv
module lane_word_allocator_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blkStart = 1'b0;
  logic [15:0] blkLen = '0;
  logic        perLaneMode = 1'b0;
  logic [1:0]  laneCfg = '0;
  logic        cntValid = 1'b0;
  logic        cntReady;
  logic [31:0] cntData = '0;
  logic        cntLast = 1'b1;
  logic        grantValid;
  logic        grantReady = 1'b0;
  logic [31:0] grantWords;
  logic [63:0] grantMask;
  logic        grantLast;
  logic        dinLast;
  logic [1:0]  errFlags;
  logic        errIrq;
  logic        dinInvert = 1'b0;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  lane_word_allocator u_lane_word_allocator (
    .clk(clk), .rstN(rstN), .blkStart(blkStart), .blkLen(blkLen),
    .perLaneMode(perLaneMode), .laneCfg(laneCfg), .cntValid(cntValid),
    .cntReady(cntReady), .cntData(cntData), .cntLast(cntLast),
    .grantValid(grantValid), .grantReady(grantReady), .grantWords(grantWords),
    .grantMask(grantMask), .grantLast(grantLast), .dinLast(dinLast),
    .errFlags(errFlags), .errIrq(errIrq)
  );

  // ---------------- behavioural reference model ----------------
  int         mRem = 0;
  logic [1:0] mErr = 2'b00;
  int         eG [4];
  int         eSum;
  logic       eGV, eCR, eGL;

  always @* begin
    int act, left, raw, req;
    act  = (laneCfg == 2'd0) ? 1 : (laneCfg == 2'd1) ? 2 : 4;
    left = mRem;
    for (int n = 0; n < 4; n++) begin
      raw = perLaneMode ? int'(cntData[8*n +: 8]) : int'(cntData[7:0]);
      req = (n < act) ? ((raw > 16) ? 16 : raw) : 0;
      eG[n] = (req < left) ? req : left;
      left  = left - eG[n];
    end
    eSum = mRem - left;
    eGV  = (mRem != 0) && !blkStart && cntValid && (eSum != 0);
    eCR  = (mRem != 0) && !blkStart && ((eSum == 0) || grantReady);
    eGL  = eGV && (left == 0);
  end

  assign dinLast = dinInvert ? !eGL : eGL;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRem <= 0;
      mErr <= 2'b00;
    end else begin
      if (eGV && grantReady && (dinLast != eGL)) mErr[0] <= 1'b1;
      if (eCR && cntValid && !cntLast)          mErr[1] <= 1'b1;
      if (blkStart)                 mRem <= int'(blkLen);
      else if (eGV && grantReady)   mRem <= mRem - eSum;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    logic [31:0] expW;
    logic [63:0] expM;
    expW = '0;
    expM = '0;
    for (int n = 0; n < 4; n++) begin
      expW[8*n +: 8] = 8'(eG[n]);
      for (int k = 0; k < 16; k++) expM[16*n + k] = (k < eG[n]);
    end
    chk("R5", "grantWords", 64'(grantWords), 64'(expW));
    chk("R9", "grantMask", grantMask, expM);
    chk("R7", "grantValid", 64'(grantValid), 64'(eGV));
    chk("R8", "cntReady", 64'(cntReady), 64'(eCR));
    chk("R6", "grantLast", 64'(grantLast), 64'(eGL));
    chk("R10", "errFlags", 64'(errFlags), 64'(mErr));
    chk("R12", "errIrq", 64'(errIrq), 64'(|mErr));
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset outputs", 64'({grantValid, cntReady, errIrq, errFlags}), 64'(0));
    rstN = 1'b1;

    // R2: zero-length start leaves the block idle
    tick();
    blkStart = 1; blkLen = 0; cntValid = 1; cntData = 32'd4; grantReady = 1;
    @(negedge clk); chk("R2", "cntReady during start", 64'(cntReady), 64'(0));
    tick(); blkStart = 0;
    @(negedge clk); chk("R2", "idle after zero length", 64'({cntReady, grantValid}), 64'(0));

    // R5: requests 8,4,2,1 with 13 words left
    tick(); blkStart = 1; blkLen = 13; perLaneMode = 1; laneCfg = 2; cntData = 32'h01020408;
    @(negedge clk); chk("R2", "no grant during start", 64'(grantValid), 64'(0));
    tick(); blkStart = 0;
    @(negedge clk);
    chk("R5", "clipped grants", 64'(grantWords), 64'h00010408);
    chk("R6", "single-beat last", 64'(grantLast), 64'(1));
    tick(); cntValid = 0;
    @(negedge clk); chk("R6", "idle after last", 64'(cntReady), 64'(0));

    // R3: shared count, two lanes, upper bytes ignored
    tick(); blkStart = 1; blkLen = 40; perLaneMode = 0; laneCfg = 1; cntData = 32'hABCDEF10;
    tick(); blkStart = 0; cntValid = 1;
    @(negedge clk); chk("R3", "shared 2-lane", 64'(grantWords), 64'h00001010);
    tick();
    @(negedge clk); chk("R3", "shortened final", 64'({grantLast, grantWords}), {31'd0, 1'b1, 32'h00000008});

    // R4: request above 16 saturates
    tick(); blkStart = 1; blkLen = 100; perLaneMode = 1; laneCfg = 0; cntData = 32'h00000014;
    tick(); blkStart = 0;
    @(negedge clk); chk("R4", "saturated request", 64'(grantWords), 64'h10);

    // R7: zero request is absorbed
    tick(); cntData = 32'h0;
    @(negedge clk); chk("R7", "zero-sum stall", 64'({cntReady, grantValid}), 64'b10);

    // R8: backpressure holds the count transfer
    tick(); cntData = 32'd5; grantReady = 0;
    @(negedge clk); chk("R8", "backpressure", 64'({cntReady, grantValid}), 64'b01);
    tick();
    @(negedge clk); chk("R8", "still held", 64'(grantWords), 64'd5);

    // R10 / R11 / R12: both error sources in one cycle
    tick(); grantReady = 1; cntLast = 0; dinInvert = 1;
    tick(); cntLast = 1; dinInvert = 0; cntValid = 0;
    @(negedge clk);
    chk("R11", "both flags set", 64'(errFlags), 64'b11);
    chk("R12", "irq", 64'(errIrq), 64'(1));

    // Random traffic
    for (int c = 0; c < 4000; c++) begin
      tick();
      blkStart = ((mRem == 0) && ($urandom % 3 == 0)) || ($urandom % 97 == 0);
      if (blkStart) begin
        blkLen      = 16'($urandom % 90);
        perLaneMode = 1'($urandom);
        laneCfg     = 2'($urandom);
      end
      cntValid = ($urandom % 4) != 0;
      for (int n = 0; n < 4; n++) cntData[8*n +: 8] = 8'($urandom % 21);
      cntLast    = ($urandom % 16) != 0;
      grantReady = ($urandom % 3) != 0;
      dinInvert  = ($urandom % 10) == 0;
    end
    tick();
    @(negedge clk);
    chk("R12", "flags still set", 64'(errFlags), 64'b11);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule